// File: doc/BRIEF.md
# Parallel Bus Target Controller

This block is the target side of a synchronous parallel bus that time-shares 32 lines between address and data. It watches for the start of a transaction, which is the first clock where the frame strobe is sampled low after being high. In that clock it reads the command from the four command/byte-enable lines and the address from the shared lines. A memory-class command whose upper address bits equal the programmed base value is claimed. The block then serves the data phases from a bank of sixteen 32-bit registers, and the word index advances by one on every completed data phase.

Every bus pin is modelled as an input, an output value and an output enable, and the board is assumed to pull the lines high. The target claims the transaction one clock after the address phase and is ready in that same clock, so it never adds wait states. Only the initiator can stretch a data phase, by holding its ready strobe high. A burst that would run past the last register is cut short: the target disconnects on the final valid word. When the target is done with a transaction it drives each of its shared strobes high for one clock before it releases them.

Top module: `mbt_target`

## Requirements
- R1: Reset clears all sixteen registers to zero and leaves every output enable (`ad_oe`, `devsel_oe`, `trdy_oe`, `stop_oe`) low.
- R2: An address phase with a memory command (0110, 1100 and 1110 read; 0111 and 1111 write) and `ad_i[31:6]` equal to `base_i` is claimed. In the next clock `devsel_n_o` and `trdy_n_o` are driven low, and the starting index is `ad_i[5:2]`.
- R3: During a claimed read, `ad_oe` is high and `ad_o` carries the register at the current index whenever `trdy_n_o` is low.
- R4: The reserved command codes 0100, 0101, 1000 and 1001 are never claimed, no output enable rises, and no register changes.
- R5: The I/O codes (0010, 0011), configuration codes (1010, 1011), codes 0000, 0001 and 1101, and memory commands whose upper address bits differ from `base_i` are not claimed and change no register.
- R6: A word moves only on a clock edge where `irdy_n_i` and `trdy_n_o` are both low. A data phase with `irdy_n_i` high is a wait state: the index does not advance, nothing is written, and read data stays on `ad_o`.
- R7: On a write, `cbe_n_i[i]` low during the data phase updates bits 8i+7..8i of the addressed register. Lanes whose enable is high keep their old value.
- R8: Each transferred word advances the index by one, so a burst of n words starting at index s touches indices s to s+n-1.
- R9: When a word transfers while `frame_n_i` is high, the transaction ends. In the next clock all three strobes are driven high with their enables set. One clock later every enable is low.
- R10: While the index is 15, `stop_n_o` is low together with `trdy_n_o`, and the word at index 15 is the last one accepted. If `frame_n_i` is still low after that word, `devsel_n_o` and `stop_n_o` stay low and `trdy_n_o` is high until `frame_n_i` is seen high. The block then parks as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_i | input | 26 | Base value compared with address bits 31..6 |
| frame_n_i | input | 1 | Frame strobe from the initiator, active low |
| irdy_n_i | input | 1 | Initiator-ready strobe, active low |
| ad_i | input | 32 | Address/data lines as seen on the bus |
| ad_o | output | 32 | Read data driven onto the address/data lines |
| ad_oe | output | 1 | Output enable for `ad_o` |
| cbe_n_i | input | 4 | Command in the address phase, active-low byte enables in data phases |
| devsel_n_o | output | 1 | Device-select strobe value, active low |
| devsel_oe | output | 1 | Output enable for device-select |
| trdy_n_o | output | 1 | Target-ready strobe value, active low |
| trdy_oe | output | 1 | Output enable for target-ready |
| stop_n_o | output | 1 | Stop strobe value, active low |
| stop_oe | output | 1 | Output enable for stop |

## Verification
Writes of three words are swept over all sixteen start indices, half of them with a wait state. This separates correct indexing from an off-by-one index, and a normal end from a disconnect on the last word, on the word before it, or on the first word. A single read burst that asks for twenty words with an initiator wait checks read data, index advance and the hold-then-park path after disconnect. A sweep of all sixteen byte-enable patterns, each followed by a read-back, shows lane mapping and polarity. Every non-memory command code and two base mismatches are then tried against a known register, and a read-back must find that register unchanged.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  typedef enum logic [3:0] {
    CMD_INTACK  = 4'h0,
    CMD_SPECIAL = 4'h1,
    CMD_IO_RD   = 4'h2,
    CMD_IO_WR   = 4'h3,
    CMD_RSV4    = 4'h4,
    CMD_RSV5    = 4'h5,
    CMD_MEM_RD  = 4'h6,
    CMD_MEM_WR  = 4'h7,
    CMD_RSV8    = 4'h8,
    CMD_RSV9    = 4'h9,
    CMD_CFG_RD  = 4'hA,
    CMD_CFG_WR  = 4'hB,
    CMD_MEM_RDM = 4'hC,
    CMD_DUALADR = 4'hD,
    CMD_MEM_RDL = 4'hE,
    CMD_MEM_WRI = 4'hF
  } bus_cmd_e;

  typedef enum logic [2:0] {
    CLS_MEM_RD,
    CLS_MEM_WR,
    CLS_IO,
    CLS_CFG,
    CLS_RSVD,
    CLS_OTHER
  } cmd_class_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_HOLD,
    ST_PARK
  } tgt_state_e;

endpackage

// File: rtl/mbt_cmd_decode.sv
module mbt_cmd_decode
  import mbt_pkg::*;
(
  input  logic [3:0] cmd_i,
  output cmd_class_e cls_o
);

  always_comb begin
    unique case (bus_cmd_e'(cmd_i))
      CMD_MEM_RD, CMD_MEM_RDM, CMD_MEM_RDL: cls_o = CLS_MEM_RD;
      CMD_MEM_WR, CMD_MEM_WRI:              cls_o = CLS_MEM_WR;
      CMD_IO_RD, CMD_IO_WR:                 cls_o = CLS_IO;
      CMD_CFG_RD, CMD_CFG_WR:               cls_o = CLS_CFG;
      CMD_RSV4, CMD_RSV5, CMD_RSV8, CMD_RSV9: cls_o = CLS_RSVD;
      default:                              cls_o = CLS_OTHER;
    endcase
  end

endmodule

// File: rtl/mbt_regfile.sv
module mbt_regfile #(
  parameter  int NREG   = 16,
  parameter  int DATA_W = 32,
  localparam int IDX_W  = $clog2(NREG),
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [LANES-1:0]  be_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] words [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DATA_W-1:0] word_q;
    logic              sel;

    assign sel = we_i && (widx_i == IDX_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (sel) begin
        for (int l = 0; l < LANES; l++) begin
          if (!be_n_i[l]) word_q[8*l +: 8] <= wdata_i[8*l +: 8];
        end
      end
    end

    assign words[r] = word_q;
  end

  assign rdata_o = words[ridx_i];

endmodule

// File: rtl/mbt_strobe.sv
module mbt_strobe (
  input  logic own_i,
  input  logic low_i,
  output logic pin_n_o,
  output logic oe_o
);

  // While owned the line is always driven: low when asked, otherwise high.
  assign oe_o    = own_i;
  assign pin_n_o = ~(own_i & low_i);

endmodule

// File: rtl/mbt_ctrl.sv
module mbt_ctrl
  import mbt_pkg::*;
#(
  parameter  int NREG  = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  input  logic             claim_i,
  input  logic             claim_rd_i,
  input  logic [IDX_W-1:0] claim_idx_i,
  output logic             xfer_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             rd_o,
  output logic             own_o,
  output logic             devsel_lo_o,
  output logic             trdy_lo_o,
  output logic             stop_lo_o,
  output logic             ad_oe_o
);

  tgt_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rd_q, rd_d;
  logic             at_end;

  assign at_end = (idx_q == IDX_W'(NREG - 1));
  assign xfer_o = (st_q == ST_XFER) && !irdy_n_i;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    rd_d  = rd_q;
    unique case (st_q)
      ST_IDLE, ST_PARK: begin
        if (claim_i) begin
          st_d  = ST_XFER;
          idx_d = claim_idx_i;
          rd_d  = claim_rd_i;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_XFER: begin
        if (xfer_o) begin
          if (frame_n_i)   st_d  = ST_PARK;
          else if (at_end) st_d  = ST_HOLD;
          else             idx_d = idx_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (frame_n_i) st_d = ST_PARK;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      rd_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      rd_q  <= rd_d;
    end
  end

  assign idx_o       = idx_q;
  assign rd_o        = rd_q;
  assign own_o       = (st_q != ST_IDLE);
  assign devsel_lo_o = (st_q == ST_XFER) || (st_q == ST_HOLD);
  assign trdy_lo_o   = (st_q == ST_XFER);
  assign stop_lo_o   = ((st_q == ST_XFER) && at_end) || (st_q == ST_HOLD);
  assign ad_oe_o     = (st_q == ST_XFER) && rd_q;

endmodule

// File: rtl/mbt_target.sv
module mbt_target
  import mbt_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int NREG   = 16,
  localparam int IDX_W  = $clog2(NREG),
  localparam int LANES  = DATA_W / 8,
  localparam int OFS_W  = $clog2(LANES),
  localparam int BASE_W = DATA_W - IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] base_i,
  input  logic              frame_n_i,
  input  logic              irdy_n_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic [LANES-1:0]  cbe_n_i,
  output logic              devsel_n_o,
  output logic              devsel_oe,
  output logic              trdy_n_o,
  output logic              trdy_oe,
  output logic              stop_n_o,
  output logic              stop_oe
);

  localparam int NSTB = 3;

  logic             frame_q;
  logic             start;
  cmd_class_e       cls;
  logic             hit;
  logic             claim;
  logic             xfer;
  logic [IDX_W-1:0] idx;
  logic             rd;
  logic             own;
  logic             devsel_lo, trdy_lo, stop_lo;
  logic [NSTB-1:0]  low_v, pin_v, oe_v;

  // Address phase: first edge with frame low after an edge with frame high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b1;
    else        frame_q <= frame_n_i;
  end

  assign start = frame_q && !frame_n_i;

  mbt_cmd_decode u_dec (
    .cmd_i (cbe_n_i[3:0]),
    .cls_o (cls)
  );

  assign hit   = (ad_i[DATA_W-1 -: BASE_W] == base_i) &&
                 ((cls == CLS_MEM_RD) || (cls == CLS_MEM_WR));
  assign claim = start && hit;

  mbt_ctrl #(.NREG(NREG)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_n_i   (frame_n_i),
    .irdy_n_i    (irdy_n_i),
    .claim_i     (claim),
    .claim_rd_i  (cls == CLS_MEM_RD),
    .claim_idx_i (ad_i[OFS_W +: IDX_W]),
    .xfer_o      (xfer),
    .idx_o       (idx),
    .rd_o        (rd),
    .own_o       (own),
    .devsel_lo_o (devsel_lo),
    .trdy_lo_o   (trdy_lo),
    .stop_lo_o   (stop_lo),
    .ad_oe_o     (ad_oe)
  );

  mbt_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (xfer && !rd),
    .widx_i  (idx),
    .be_n_i  (cbe_n_i),
    .wdata_i (ad_i),
    .ridx_i  (idx),
    .rdata_o (ad_o)
  );

  assign low_v = {stop_lo, trdy_lo, devsel_lo};

  for (genvar s = 0; s < NSTB; s++) begin : g_stb
    mbt_strobe u_stb (
      .own_i   (own),
      .low_i   (low_v[s]),
      .pin_n_o (pin_v[s]),
      .oe_o    (oe_v[s])
    );
  end

  assign devsel_n_o = pin_v[0];
  assign devsel_oe  = oe_v[0];
  assign trdy_n_o   = pin_v[1];
  assign trdy_oe    = oe_v[1];
  assign stop_n_o   = pin_v[2];
  assign stop_oe    = oe_v[2];

endmodule

// File: rtl/mbt_target_chk.sv
module mbt_target_chk #(
  parameter int BASE_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_n_i,
  input logic [3:0]        cmd_i,
  input logic [BASE_W-1:0] base_i,
  input logic [BASE_W-1:0] ad_hi_i,
  input logic              ad_oe,
  input logic              devsel_n_o,
  input logic              devsel_oe,
  input logic              trdy_n_o,
  input logic              trdy_oe,
  input logic              stop_n_o,
  input logic              stop_oe
);

  logic fr_q;
  logic begin_ph;
  logic rsvd_cmd;
  logic mem_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fr_q <= 1'b1;
    else        fr_q <= frame_n_i;
  end

  assign begin_ph = fr_q && !frame_n_i;
  assign rsvd_cmd = cmd_i inside {4'h4, 4'h5, 4'h8, 4'h9};
  assign mem_cmd  = cmd_i inside {4'h6, 4'h7, 4'hC, 4'hE, 4'hF};

  assert_claim_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_ph && mem_cmd && (ad_hi_i == base_i) && !devsel_oe) |=>
      (devsel_oe && !devsel_n_o && trdy_oe && !trdy_n_o));

  assert_ready_with_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && !trdy_n_o) |-> (devsel_oe && !devsel_n_o));

  assert_read_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (trdy_oe && !trdy_n_o));

  assert_rsvd_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_ph && rsvd_cmd && !devsel_oe) |=> !devsel_oe);

  assert_devsel_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_oe) |-> $past(devsel_n_o));

  assert_trdy_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_oe) |-> $past(trdy_n_o));

  assert_stop_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_oe) |-> $past(stop_n_o));

  assert_stop_with_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_oe && !stop_n_o) |-> (devsel_oe && !devsel_n_o));

endmodule

bind mbt_target mbt_target_chk #(.BASE_W(BASE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n_i  (frame_n_i),
  .cmd_i      (cbe_n_i[3:0]),
  .base_i     (base_i),
  .ad_hi_i    (ad_i[DATA_W-1 -: BASE_W]),
  .ad_oe      (ad_oe),
  .devsel_n_o (devsel_n_o),
  .devsel_oe  (devsel_oe),
  .trdy_n_o   (trdy_n_o),
  .trdy_oe    (trdy_oe),
  .stop_n_o   (stop_n_o),
  .stop_oe    (stop_oe)
);

// File: tb/mbt_target_tb.sv
module mbt_target_tb;

  localparam logic [25:0] BASE = 26'h2A51C3;
  localparam int NR = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] base_i = BASE;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_o;
  logic        ad_oe, devsel_n_o, devsel_oe, trdy_n_o, trdy_oe, stop_n_o, stop_oe;

  int checks = 0;
  int failures = 0;
  bit ended = 0;
  logic [31:0] model [NR];

  always #10 clk = ~clk;

  mbt_target u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_i     (base_i),
    .frame_n_i  (frame_n),
    .irdy_n_i   (irdy_n),
    .ad_i       (ad_i),
    .ad_o       (ad_o),
    .ad_oe      (ad_oe),
    .cbe_n_i    (cbe_n),
    .devsel_n_o (devsel_n_o),
    .devsel_oe  (devsel_oe),
    .trdy_n_o   (trdy_n_o),
    .trdy_oe    (trdy_oe),
    .stop_n_o   (stop_n_o),
    .stop_oe    (stop_oe)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(input int cur, input int k, input int seed);
    return {8'(seed * 37 + 11), 8'(cur * 17 + 3), 8'(k * 29 + 5), 8'(seed ^ 8'h6C)};
  endfunction

  task automatic xact(input logic [3:0] cmd, input logic [25:0] b, input int idx, input int n,
                      input logic [3:0] be, input bit wt, input int seed, input string tag);
    bit mem = (cmd == 4'h6 || cmd == 4'h7 || cmd == 4'hC || cmd == 4'hE || cmd == 4'hF);
    bit rd  = (cmd == 4'h6 || cmd == 4'hC || cmd == 4'hE);
    bit hit = mem && (b == BASE);
    int cur = idx;
    int k = 0;
    int exp_words;
    bit stopped = 0;
    bit done = 0;
    bit waited = 0;
    bit last = 0;
    logic [31:0] w;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_i = {b, 4'(idx), 2'b00}; cbe_n = cmd;
    @(negedge clk);
    if (!hit) begin
      for (int j = 0; j < n; j++) begin
        irdy_n = 1'b0; frame_n = (j == n - 1); ad_i = wd(3, j, seed); cbe_n = be;
        chk({tag, " R4 R5"}, "no claim enables", {devsel_oe, trdy_oe, stop_oe, ad_oe}, 4'b0000);
        @(negedge clk);
      end
      irdy_n = 1'b1; frame_n = 1'b1;
      chk({tag, " R4 R5"}, "no claim after end", {devsel_oe, trdy_oe, stop_oe, ad_oe}, 4'b0000);
    end else begin
      exp_words = (n < NR - idx) ? n : NR - idx;
      while (!done) begin
        if (wt && k == 1 && !waited) begin
          irdy_n = 1'b1; frame_n = 1'b0; ad_i = '0;
          chk({tag, " R6"}, "target ready in wait", {trdy_oe, trdy_n_o}, 2'b10);
          if (rd) chk({tag, " R6"}, "read data held in wait", ad_o, model[cur]);
          @(negedge clk);
          waited = 1;
        end
        last = (k == n - 1);
        w = wd(cur, k, seed);
        irdy_n = 1'b0; frame_n = last; ad_i = rd ? 32'h0 : w; cbe_n = rd ? 4'h0 : be;
        chk({tag, " R2"}, "select/ready low", {devsel_oe, devsel_n_o, trdy_oe, trdy_n_o}, 4'b1010);
        chk({tag, " R10"}, "stop at word", {stop_oe, stop_n_o}, {1'b1, cur != NR - 1});
        if (rd) begin
          chk({tag, " R3"}, "ad drive", ad_oe, 1'b1);
          chk({tag, " R3 R8"}, $sformatf("read data idx %0d", cur), ad_o, model[cur]);
        end else begin
          chk({tag, " R3"}, "no ad drive on write", ad_oe, 1'b0);
        end
        @(negedge clk);
        if (!rd) begin
          for (int l = 0; l < 4; l++) if (!be[l]) model[cur][8*l +: 8] = w[8*l +: 8];
        end
        stopped = (cur == NR - 1);
        cur++; k++;
        done = stopped || last;
      end
      chk({tag, " R8"}, "words moved", k, exp_words);
      if (stopped && !last) begin
        irdy_n = 1'b1; frame_n = 1'b1;
        chk({tag, " R10"}, "hold after disconnect",
            {devsel_n_o, trdy_n_o, stop_n_o, devsel_oe, trdy_oe, stop_oe}, 6'b010111);
        @(negedge clk);
      end
      irdy_n = 1'b1; frame_n = 1'b1;
      chk({tag, " R9"}, "park high",
          {devsel_oe, trdy_oe, stop_oe, devsel_n_o, trdy_n_o, stop_n_o, ad_oe}, 7'b1111110);
      @(negedge clk);
      chk({tag, " R9"}, "released", {devsel_oe, trdy_oe, stop_oe, ad_oe}, 4'b0000);
    end
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "enables in reset", {devsel_oe, trdy_oe, stop_oe, ad_oe}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "enables after reset", {devsel_oe, trdy_oe, stop_oe, ad_oe}, 4'b0000);
    xact(4'h6, BASE, 7, 1, 4'h0, 0, 0, "R1 cleared reg");

    for (int s = 0; s < NR; s++) xact(4'h7, BASE, s, 3, 4'h0, (s % 2) == 1, s, "R8 write sweep");

    xact(4'h6, BASE, 0, 20, 4'h0, 1, 0, "R10 long read");
    xact(4'hC, BASE, 13, 3, 4'h0, 0, 0, "R10 stop on last");
    xact(4'hE, BASE, 15, 1, 4'h0, 0, 0, "R10 single at end");
    xact(4'h7, BASE, 15, 4, 4'h0, 0, 77, "R10 write first word stop");

    for (int be = 0; be < 16; be++) begin
      xact(4'hF, BASE, 5, 1, 4'(be), 0, 100 + be, "R7 lane write");
      xact(4'hE, BASE, 5, 1, 4'h0, 0, 0, "R7 lane readback");
    end

    for (int c = 0; c < 16; c++) begin
      if (!(c == 6 || c == 7 || c == 12 || c == 14 || c == 15)) begin
        xact(4'(c), BASE, 3, 2, 4'h0, 0, 200 + c, (c inside {4, 5, 8, 9}) ? "R4 reserved" : "R5 other cmd");
        xact(4'h6, BASE, 3, 1, 4'h0, 0, 0, "R4 R5 reg3 unchanged");
      end
    end
    xact(4'h7, BASE ^ 26'h1, 3, 2, 4'h0, 0, 300, "R5 base miss low");
    xact(4'h7, BASE ^ 26'h2000000, 3, 2, 4'h0, 0, 301, "R5 base miss high");
    xact(4'h6, BASE, 3, 1, 4'h0, 0, 0, "R5 reg3 unchanged");
    xact(4'h6, BASE, 0, 16, 4'h0, 1, 0, "R6 final readback");

    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", checks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule